// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the transmit-data inputs of a multi-channel bus transceiver and the enables of its bus drivers. Each channel has one transmit input: high asks for the recessive bus state and low asks for the dominant state. The block decides, cycle by cycle, whether the driver of that channel may actually pull the bus dominant. It stops a transmit input that is stuck low from holding the bus dominant forever. It also shuts all drivers down while the die is too hot, and it brings each driver back without oscillation once the die has cooled.

Every channel counts how many consecutive clock cycles its transmit input has been low while the channel is in normal mode. When that run reaches `TMO_CYCLES`, the driver of that channel is latched off until the transmit input goes high again. The default value corresponds to about 2 ms at 125 MHz. This limit also sets the lowest bit rate the link can carry.

A single overtemperature flag is shared by all channels and switches every driver off at once. When the flag clears, each channel stays off until its own transmit input has been seen high at a clock edge, so small temperature changes around the threshold cannot make a driver toggle. A channel that is not in normal mode never drives, and its timer is held cleared.

Top module: `txdom_guard`

## Requirements
- R1: While `rst` is high, every bit of `drv_dom_o` is 0. A synchronous reset clears the timeout state and the thermal latch, so after release a channel whose transmit input is low gets a full `TMO_CYCLES` window.
- R2: In normal mode, with no overtemperature and no active latch, `drv_dom_o[c]` is 1 in the same cycle that `txd_i[c]` is 0. It is 0 whenever `txd_i[c]` is 1.
- R3: After `TMO_CYCLES` consecutive rising clock edges with `txd_i[c]`=0 in normal mode, `drv_dom_o[c]` becomes 0. It stays 0 for as long as the low level lasts, however long that is, and the counter never wraps back around to re-enable the driver.
- R4: One rising edge with `txd_i[c]`=1 clears the timeout of channel c. The next low level then drives dominant again for a full `TMO_CYCLES` window.
- R5: The channels have independent timers. The low run, timeout or release of one channel never changes the output of another channel.
- R6: While `ovt_i`=1, every bit of `drv_dom_o` is 0 in that same cycle.
- R7: A rising edge with `ovt_i`=1 latches every channel off. After `ovt_i` returns to 0, channel c stays off until a rising edge sees `txd_i[c]`=1, and each channel recovers on its own.
- R8: When `normal_i[c]`=0 (standby), `drv_dom_o[c]` is 0 and the timer of channel c is held cleared. Low cycles spent in standby therefore do not count toward the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txd_i | input | NCH | Transmit data per channel; 0 requests dominant, 1 requests recessive |
| normal_i | input | NCH | Mode per channel; 1 means normal mode, 0 means standby |
| ovt_i | input | 1 | Overtemperature flag shared by all channels, active high |
| drv_dom_o | output | NCH | 1 when the driver of the channel pulls the bus dominant |

## Verification
The hardest situation to reach from the ports is the saturated timeout: a channel held low far beyond the window, where a wrapping counter would quietly switch the driver back on. The bench builds the block with a short window and holds one channel low for several full windows. While it does so, it starts the second channel's low run half a window later, so the two timeouts land in different cycles. The oscillation-free thermal recovery is reached by clearing the flag while a transmit input is still low. The bench then releases the two channels in different cycles and checks that each driver stays off until its own input has gone high.

// File: rtl/txg_pkg.sv
package txg_pkg;

    // Per-channel request as seen at the block inputs.
    typedef struct packed {
        logic dom_req;   // transmit input low
        logic in_norm;   // channel in normal mode
    } txg_req_t;

    // Per-channel inhibit reasons.
    typedef struct packed {
        logic expired;   // dominant run reached the limit
        logic hot;       // thermal inhibit (live flag or latch)
    } txg_inh_t;

    function automatic int unsigned txg_cnt_w(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic logic txg_may_drive(input txg_req_t r, input txg_inh_t i);
        return r.dom_req & r.in_norm & ~i.expired & ~i.hot;
    endfunction

endpackage

// File: rtl/txg_timer.sv
module txg_timer
    import txg_pkg::*;
#(
    parameter int unsigned TMO_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = txg_cnt_w(TMO_CYCLES);
    localparam logic [CW-1:0] LIMIT = CW'(TMO_CYCLES);

    logic [CW-1:0] cnt_q;

    // Saturating count of consecutive cycles with run set.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LIMIT);
endmodule

// File: rtl/txg_thermal.sv
module txg_thermal (
    input  logic clk,
    input  logic rst,
    input  logic ovt,
    input  logic txd_high,
    output logic hot
);
    logic lat_q;

    // Set by the flag; released only with flag gone and input recessive.
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= 1'b0;
        end else if (ovt) begin
            lat_q <= 1'b1;
        end else if (txd_high) begin
            lat_q <= 1'b0;
        end
    end

    assign hot = ovt | lat_q;
endmodule

// File: rtl/txg_channel.sv
module txg_channel
    import txg_pkg::*;
#(
    parameter int unsigned TMO_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic txd,
    input  logic normal,
    input  logic ovt,
    output logic drv_dom
);
    txg_req_t req;
    txg_inh_t inh;

    assign req.dom_req = ~txd;
    assign req.in_norm = normal;

    txg_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (req.dom_req & req.in_norm),
        .expired (inh.expired)
    );

    txg_thermal u_therm (
        .clk      (clk),
        .rst      (rst),
        .ovt      (ovt),
        .txd_high (txd),
        .hot      (inh.hot)
    );

    assign drv_dom = ~rst & txg_may_drive(req, inh);
endmodule

// File: rtl/txdom_guard.sv
module txdom_guard
    import txg_pkg::*;
#(
    parameter int unsigned NCH        = 2,
    parameter int unsigned TMO_CYCLES = 250000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] txd_i,
    input  logic [NCH-1:0] normal_i,
    input  logic           ovt_i,
    output logic [NCH-1:0] drv_dom_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        txg_channel #(.TMO_CYCLES(TMO_CYCLES)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .txd     (txd_i[c]),
            .normal  (normal_i[c]),
            .ovt     (ovt_i),
            .drv_dom (drv_dom_o[c])
        );
    end
endmodule

// File: rtl/txdom_guard_chk.sv
module txdom_guard_chk
    import txg_pkg::*;
#(
    parameter int unsigned NCH        = 2,
    parameter int unsigned TMO_CYCLES = 250000
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] txd_i,
    input logic [NCH-1:0] normal_i,
    input logic           ovt_i,
    input logic [NCH-1:0] drv_dom_o
);
    localparam int unsigned CW = txg_cnt_w(TMO_CYCLES);
    localparam logic [CW-1:0] LIMIT = CW'(TMO_CYCLES);

    // Reset-time output must be quiet.
    always_comb begin
        if (rst) a_reset_quiet_r1 : assert (drv_dom_o == '0);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        logic [CW-1:0] run_q;

        always_ff @(posedge clk) begin
            if (rst || !(normal_i[c] && !txd_i[c])) run_q <= '0;
            else if (run_q != LIMIT) run_q <= run_q + 1'b1;
        end

        // R3: a full low run in normal mode means no drive.
        p_limit_off_r3 : assert property (@(posedge clk) disable iff (rst)
            (run_q == LIMIT) |-> !drv_dom_o[c]);

        // R6: live overtemperature silences the channel.
        p_hot_off_r6 : assert property (@(posedge clk) disable iff (rst)
            ovt_i |-> !drv_dom_o[c]);

        // R8: standby never drives.
        p_standby_off_r8 : assert property (@(posedge clk) disable iff (rst)
            !normal_i[c] |-> !drv_dom_o[c]);

        // R7: once off during an unbroken low run, the driver stays off.
        p_stays_off_r7 : assert property (@(posedge clk) disable iff (rst)
            (!txd_i[c] && normal_i[c] && $past(!txd_i[c] && normal_i[c] && !drv_dom_o[c] && !rst))
            |-> !drv_dom_o[c]);

        // R4: dominant drive starts only after a recessive input, a mode entry or a reset.
        p_rise_cause_r4 : assert property (@(posedge clk) disable iff (rst)
            $rose(drv_dom_o[c]) |-> ($past(txd_i[c]) || !$past(normal_i[c]) || $past(rst)));
    end
endmodule

bind txdom_guard txdom_guard_chk #(.NCH(NCH), .TMO_CYCLES(TMO_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .txd_i     (txd_i),
    .normal_i  (normal_i),
    .ovt_i     (ovt_i),
    .drv_dom_o (drv_dom_o)
);

// File: tb/txdom_guard_bench.sv
module txdom_guard_bench;
    localparam int unsigned NCH = 2;
    localparam int unsigned TMO = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] txd_i = '1;
    logic [NCH-1:0] normal_i = '1;
    logic           ovt_i = 1'b0;
    logic [NCH-1:0] drv_dom_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    txdom_guard #(.NCH(NCH), .TMO_CYCLES(TMO)) u_txdom_guard (
        .clk(clk), .rst(rst), .txd_i(txd_i), .normal_i(normal_i),
        .ovt_i(ovt_i), .drv_dom_o(drv_dom_o)
    );

    task automatic check(input logic [NCH-1:0] exp, input string tag);
        n_chk++;
        if (drv_dom_o !== exp) begin
            n_bad++;
            $display("FAIL %s: drv_dom_o=%b expected %b (t=%0t)", tag, drv_dom_o, exp, $time);
        end
    endtask

    // Drive at the falling edge, sample 1 ns later.
    task automatic step(input logic [1:0] t, input logic [1:0] n, input logic o);
        @(negedge clk);
        txd_i = t; normal_i = n; ovt_i = o;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; txd_i = '1; normal_i = '1; ovt_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Fields: {txd[1:0], normal[1:0], ovt, expected drv[1:0]}
    localparam int NV = 11;
    localparam logic [6:0] VEC [NV] = '{
        {2'b11, 2'b11, 1'b0, 2'b00},  // R2 recessive
        {2'b10, 2'b11, 1'b0, 2'b01},  // R2 ch0 dominant
        {2'b00, 2'b11, 1'b0, 2'b11},  // R5 both
        {2'b00, 2'b11, 1'b1, 2'b00},  // R6 hot
        {2'b00, 2'b11, 1'b0, 2'b00},  // R7 latched
        {2'b01, 2'b11, 1'b0, 2'b00},  // R7 ch0 high releases
        {2'b00, 2'b11, 1'b0, 2'b01},  // R7 ch0 back, ch1 held
        {2'b10, 2'b11, 1'b0, 2'b01},  // R7 ch1 high releases
        {2'b00, 2'b11, 1'b0, 2'b11},  // R7 both back
        {2'b00, 2'b01, 1'b0, 2'b01},  // R8 ch1 standby
        {2'b11, 2'b11, 1'b0, 2'b00}   // R2 recessive
    };

    initial begin : watchdog
        wait (cyc > 50000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, got cycle %0d expected < 50000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        // R1: quiet during reset even with a dominant request.
        @(negedge clk); txd_i = 2'b00; #1;
        check(2'b00, "R1 reset quiet");
        do_reset();

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][6:5], VEC[i][4:3], VEC[i][2]);
            check(VEC[i][1:0], $sformatf("vector %0d", i));
        end

        // R3/R5: timeout, saturation, independent timing.
        do_reset();
        for (int i = 0; i < 6 * TMO; i++) begin
            logic [1:0] t;
            logic [1:0] e;
            t[0] = 1'b0;
            t[1] = (i < TMO / 2) ? 1'b1 : 1'b0;
            step(t, 2'b11, 1'b0);
            e[0] = (i < TMO);
            e[1] = (i >= TMO / 2) && (i < TMO / 2 + TMO);
            if (i == TMO - 1 || i == TMO || i == TMO / 2 + TMO || i == 6 * TMO - 1)
                check(e, $sformatf("R3 R5 run cycle %0d", i));
        end
        // R4: one recessive edge clears, new full window.
        step(2'b11, 2'b11, 1'b0);
        check(2'b00, "R4 recessive");
        for (int i = 0; i <= TMO; i++) begin
            step(2'b10, 2'b11, 1'b0);
            if (i == 0 || i == TMO - 1) check(2'b01, $sformatf("R4 rearmed %0d", i));
            if (i == TMO) check(2'b00, "R4 second timeout");
        end

        // R8: low time in standby does not count.
        step(2'b11, 2'b11, 1'b0);
        for (int i = 0; i < 3 * TMO; i++) step(2'b10, 2'b10, 1'b0);
        check(2'b00, "R8 standby no drive");
        for (int i = 0; i < TMO; i++) step(2'b10, 2'b11, 1'b0);
        check(2'b01, "R8 full window after standby");

        // R1: reset clears a timed-out channel.
        step(2'b10, 2'b11, 1'b0);
        check(2'b00, "R1 timed out before reset");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); #1;
        check(2'b00, "R1 in reset");
        rst = 1'b0; #1;
        check(2'b01, "R1 window after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule